// File: doc/BRIEF.md
# Shared Arithmetic, Logic and Compare Unit

This block is the purely combinational execute stage of a small 16-bit processor. One unit serves arithmetic, the six bitwise functions, the six signed comparisons and a one-position rotate. No separate comparator is needed. The caller supplies two operands, a 4-bit operation class taken from the instruction's major opcode and a 4-bit secondary function code. The function code chooses among the logic functions or the compare functions when the class is one of those two. The block returns a single 16-bit result in the same cycle.

For the immediate-add class, the caller has already sign-extended the 8-bit immediate onto the second operand. The unit then treats it exactly like a register add. A compare produces a boolean word, and the caller writes it into the condition register. Wider rotates are built in software by looping on the single-bit rotate.

Top module: `shared_alu`

## Requirements
- R1: Classes 0000 (add) and 0001 (immediate add) return opA + opB modulo 2^16. There is no carry or overflow output.
- R2: Class 0010 (subtract) returns opA - opB modulo 2^16.
- R3: Class 0011 (logic) returns the bitwise AND, OR, NAND, NOR, XOR or XNOR of the operands, for function codes 0000, 0001, 0010, 0011, 0100 and 0101 in that order.
- R4: Class 0100 (compare) returns 16'h0001 when the relation holds and 16'h0000 when it does not. The relations are opA > opB (0000), opA < opB (0001), opA >= opB (0010), opA <= opB (0011), opA == opB (0100) and opA != opB (0101).
- R5: Compares treat both operands as signed two's-complement values. This includes pairs whose difference overflows, such as 16'h8000 against 16'h7FFF.
- R6: Class 1001 (rotate) returns opA rotated left by exactly one position: bit 15 moves to bit 0. opB has no effect on the result.
- R7: In the logic and compare classes, function codes 0110 through 1111 return 16'h0000.
- R8: Every class other than 0000, 0001, 0010, 0011, 0100 and 1001 returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opClass | input | 4 | Major operation class from the instruction opcode |
| funcCode | input | 4 | Secondary function selecting the logic or compare variant |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand (register value or sign-extended immediate) |
| result | output | 16 | Operation result, or boolean word for compares |

## Verification
The subtract class and the compare class drive the same difference logic. A single operand pair therefore decides both a subtraction result and the outcome of all six signed relations. The bench provokes this by applying the same operand pairs to the subtract class and to every compare code. It concentrates on pairs that straddle the sign boundary, where the raw difference sign is wrong and only the overflow correction gives the right answer. Each output is judged against a bench model that compares with native signed arithmetic rather than through a difference.

// File: rtl/shared_alu_pkg.sv
package shared_alu_pkg;

  localparam logic [3:0] CLS_ADD   = 4'b0000;
  localparam logic [3:0] CLS_ADDI  = 4'b0001;
  localparam logic [3:0] CLS_SUB   = 4'b0010;
  localparam logic [3:0] CLS_LOGIC = 4'b0011;
  localparam logic [3:0] CLS_CMP   = 4'b0100;
  localparam logic [3:0] CLS_ROL   = 4'b1001;

  localparam int FUNC_COUNT = 6;

  typedef enum logic [3:0] {
    LF_AND  = 4'd0,
    LF_OR   = 4'd1,
    LF_NAND = 4'd2,
    LF_NOR  = 4'd3,
    LF_XOR  = 4'd4,
    LF_XNOR = 4'd5
  } logicFn_e;

  typedef enum logic [3:0] {
    CF_GT = 4'd0,
    CF_LT = 4'd1,
    CF_GE = 4'd2,
    CF_LE = 4'd3,
    CF_EQ = 4'd4,
    CF_NE = 4'd5
  } cmpFn_e;

  typedef struct packed {
    logic     doAdd;
    logic     doSub;
    logic     doLogic;
    logic     doCmp;
    logic     doRol;
    logicFn_e logicFn;
    cmpFn_e   cmpFn;
  } aluCtrl_t;

endpackage

// File: rtl/shared_alu_ctrl.sv
module shared_alu_ctrl
  import shared_alu_pkg::*;
(
  input  logic [3:0] opClass,
  input  logic [3:0] funcCode,
  output aluCtrl_t   ctrl
);

  logic funcOk;
  assign funcOk = (funcCode < 4'(FUNC_COUNT));

  always_comb begin
    ctrl         = '0;
    ctrl.logicFn = LF_AND;
    ctrl.cmpFn   = CF_GT;
    case (opClass)
      CLS_ADD, CLS_ADDI: ctrl.doAdd = 1'b1;
      CLS_SUB:           ctrl.doSub = 1'b1;
      CLS_LOGIC: begin
        ctrl.doLogic = funcOk;
        ctrl.logicFn = logicFn_e'(funcCode);
      end
      CLS_CMP: begin
        ctrl.doCmp = funcOk;
        ctrl.cmpFn = cmpFn_e'(funcCode);
      end
      CLS_ROL:           ctrl.doRol = 1'b1;
      default:           ctrl.doAdd = 1'b0;
    endcase
  end

  // R3/R4: at most one result path may be enabled
  always_comb begin
    if (!$isunknown({opClass, funcCode}))
      p_single_path_r3: assert ($onehot0({ctrl.doAdd, ctrl.doSub, ctrl.doLogic,
                                          ctrl.doCmp, ctrl.doRol}));
  end

endmodule

// File: rtl/shared_alu_datapath.sv
module shared_alu_datapath
  import shared_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluCtrl_t            ctrl,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic [DATA_W-1:0]   result
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sumVal, diffVal, logicVal, rolVal, cmpVal;
  logic              diffOvf, isLess, isEq, cmpBit;

  assign sumVal  = opA + opB;
  assign diffVal = opA - opB;

  // Signed ordering taken from the shared subtractor with overflow fix-up
  assign diffOvf = (opA[MSB] ^ opB[MSB]) & (opA[MSB] ^ diffVal[MSB]);
  assign isLess  = diffVal[MSB] ^ diffOvf;
  assign isEq    = ~|diffVal;

  always_comb begin
    case (ctrl.cmpFn)
      CF_GT:   cmpBit = ~isLess & ~isEq;
      CF_LT:   cmpBit = isLess;
      CF_GE:   cmpBit = ~isLess;
      CF_LE:   cmpBit = isLess | isEq;
      CF_EQ:   cmpBit = isEq;
      CF_NE:   cmpBit = ~isEq;
      default: cmpBit = 1'b0;
    endcase
  end
  assign cmpVal = {{(DATA_W-1){1'b0}}, cmpBit};

  always_comb begin
    case (ctrl.logicFn)
      LF_AND:  logicVal = opA & opB;
      LF_OR:   logicVal = opA | opB;
      LF_NAND: logicVal = ~(opA & opB);
      LF_NOR:  logicVal = ~(opA | opB);
      LF_XOR:  logicVal = opA ^ opB;
      LF_XNOR: logicVal = ~(opA ^ opB);
      default: logicVal = '0;
    endcase
  end

  generate
    if (DATA_W > 1) begin : g_rotWide
      assign rolVal = {opA[MSB-1:0], opA[MSB]};
    end else begin : g_rotBit
      assign rolVal = opA;
    end
  endgenerate

  // AND-OR result selection driven by one-hot strobes
  assign result = ({DATA_W{ctrl.doAdd}}   & sumVal)
                | ({DATA_W{ctrl.doSub}}   & diffVal)
                | ({DATA_W{ctrl.doLogic}} & logicVal)
                | ({DATA_W{ctrl.doCmp}}   & cmpVal)
                | ({DATA_W{ctrl.doRol}}   & rolVal);

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      p_sum_inverse_r1:  assert ((sumVal - opB) == opA);
      p_diff_inverse_r2: assert ((diffVal + opB) == opA);
      p_signed_order_r5: assert (isLess == ($signed(opA) < $signed(opB)));
      p_rot_ones_r6:     assert ($countones(rolVal) == $countones(opA));
    end
  end

endmodule

// File: rtl/shared_alu.sv
module shared_alu
  import shared_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        opClass,
  input  logic [3:0]        funcCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  aluCtrl_t ctrl;

  shared_alu_ctrl u_ctrl (
    .opClass  (opClass),
    .funcCode (funcCode),
    .ctrl     (ctrl)
  );

  shared_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

  always_comb begin
    if (!$isunknown({opClass, funcCode, opA, opB})) begin
      if (ctrl.doCmp)
        p_cmp_boolean_r4: assert (result[DATA_W-1:1] == '0);
      if (!(ctrl.doAdd | ctrl.doSub | ctrl.doLogic | ctrl.doCmp | ctrl.doRol))
        p_idle_zero_r8: assert (result == '0);
    end
  end

endmodule

// File: tb/shared_alu_tb_top.sv
`timescale 1ns/1ps
module shared_alu_tb_top;

  logic        clk = 1'b0;
  logic [3:0]  opClass, funcCode;
  logic [15:0] opA, opB, result;
  int          nVec = 0, nBad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  shared_alu dut_i (
    .opClass(opClass), .funcCode(funcCode), .opA(opA), .opB(opB), .result(result)
  );

  function automatic logic [15:0] model(input logic [3:0] oc, input logic [3:0] fc,
                                        input logic [15:0] a, input logic [15:0] b);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    case (oc)
      4'd0, 4'd1: return a + b;
      4'd2:       return a - b;
      4'd3: case (fc)
              4'd0: return a & b;
              4'd1: return a | b;
              4'd2: return ~(a & b);
              4'd3: return ~(a | b);
              4'd4: return a ^ b;
              4'd5: return ~(a ^ b);
              default: return 16'h0000;
            endcase
      4'd4: case (fc)
              4'd0: return (sa >  sb) ? 16'h1 : 16'h0;
              4'd1: return (sa <  sb) ? 16'h1 : 16'h0;
              4'd2: return (sa >= sb) ? 16'h1 : 16'h0;
              4'd3: return (sa <= sb) ? 16'h1 : 16'h0;
              4'd4: return (sa == sb) ? 16'h1 : 16'h0;
              4'd5: return (sa != sb) ? 16'h1 : 16'h0;
              default: return 16'h0000;
            endcase
      4'd9:       return {a[14:0], a[15]};
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] oc, input logic [3:0] fc,
                                  input logic [15:0] a, input logic [15:0] b);
    case (oc)
      4'd0, 4'd1: return "R1";
      4'd2:       return "R2";
      4'd3:       return (fc > 4'd5) ? "R7" : "R3";
      4'd4:       return (fc > 4'd5) ? "R7" : ((a[15] != b[15]) ? "R5" : "R4");
      4'd9:       return "R6";
      default:    return "R8";
    endcase
  endfunction

  task automatic apply(input logic [3:0] oc, input logic [3:0] fc,
                       input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [15:0] exp;
    @(negedge clk);
    opClass = oc; funcCode = fc; opA = a; opB = b;
    #1;
    exp = model(oc, fc, a, b);
    nVec++;
    if (result !== exp) begin
      nBad++;
      $display("FAIL %s cls=%h fn=%h a=%h b=%h actual=%h expected=%h",
               tag, oc, fc, a, b, result, exp);
    end
  endtask

  function automatic logic [15:0] pickOperand();
    case ($urandom % 8)
      0: return 16'h0000;
      1: return 16'h7FFF;
      2: return 16'h8000;
      3: return 16'hFFFF;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    logic [3:0]  oc, fc;
    logic [15:0] a, b;
    void'($urandom(32'd20240611));
    opClass = '0; funcCode = '0; opA = '0; opB = '0;
    // quiescent all-zero inputs
    apply(4'd0, 4'd0, 16'h0000, 16'h0000, "R1");
    // R1 wrap and immediate add with negative sign-extended value
    apply(4'd0, 4'd0, 16'hFFFF, 16'h0001, "R1");
    apply(4'd1, 4'd0, 16'h0010, 16'hFFFE, "R1");
    // R2 borrow wrap
    apply(4'd2, 4'd0, 16'h0000, 16'h0001, "R2");
    // R3 each logic function
    for (int f = 0; f < 6; f++) apply(4'd3, 4'(f), 16'hF0CC, 16'hAA0F, "R3");
    // R4 equal operands across all relations
    for (int f = 0; f < 6; f++) apply(4'd4, 4'(f), 16'h1234, 16'h1234, "R4");
    // R5 overflowing differences against subtract on same pair
    for (int f = 0; f < 6; f++) begin
      apply(4'd4, 4'(f), 16'h8000, 16'h7FFF, "R5");
      apply(4'd4, 4'(f), 16'h7FFF, 16'h8000, "R5");
      apply(4'd4, 4'(f), 16'hFFFF, 16'h0001, "R5");
    end
    apply(4'd2, 4'd0, 16'h8000, 16'h7FFF, "R2");
    // R6 rotate with differing opB
    apply(4'd9, 4'd0, 16'h8001, 16'h0000, "R6");
    apply(4'd9, 4'd7, 16'h8001, 16'hFFFF, "R6");
    // R7 undefined function codes
    for (int f = 6; f < 16; f++) begin
      apply(4'd3, 4'(f), 16'hFFFF, 16'h0F0F, "R7");
      apply(4'd4, 4'(f), 16'h0001, 16'h0001, "R7");
    end
    // R8 unused classes
    for (int c = 5; c < 16; c++)
      if (c != 9) apply(4'(c), 4'd0, 16'hFFFF, 16'hFFFF, "R8");
    // constrained random, subtract and compare interleaved on shared pairs
    for (int i = 0; i < 3000; i++) begin
      a = pickOperand();
      b = pickOperand();
      case ($urandom % 10)
        0: oc = 4'd0;
        1: oc = 4'd1;
        2: oc = 4'd2;
        3: oc = 4'd3;
        4, 5: oc = 4'd4;
        6: oc = 4'd9;
        default: oc = 4'($urandom);
      endcase
      fc = ($urandom % 4 == 0) ? 4'($urandom) : 4'($urandom % 6);
      apply(oc, fc, a, b, tagOf(oc, fc, a, b));
      if (oc == 4'd4) apply(4'd2, fc, a, b, "R2");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule